// File: doc/BRIEF.md
# Top-Three Candidate Ranking Sorter

This block takes track candidates from nine source links. Each link can supply up to two candidates per bunch crossing, so each crossing holds eighteen candidates. The block picks the three best of the eighteen. It places them on three output channels in ranked order, best on channel 0. Each output word is tagged with the link the candidate came from and with the candidate's position within that link. In the same cycle the block returns a winner bit for every input candidate, which tells each source which of its candidates were chosen.

The block is fully pipelined. It accepts a new set of eighteen candidates on every clock and returns the result for that set a fixed three cycles later, with a valid strobe carried alongside the data. The block does not sort all eighteen inputs. Each candidate computes how many of the others outrank it. A candidate whose count is 0, 1 or 2 lands on the channel with that number.

Top module: `top3_ranker`

## Requirements
- R1: `out_valid` equals the `in_valid` applied three clock edges earlier. The words and flags for that input set appear in the same cycle as the strobe.
- R2: Output channel n sits at bits `[n*17 +: 17]` of `out_words`. Each word is `{quality[3:0], payload[7:0], src_id[3:0], sub[0]}`, with quality in the top four bits. Channel 0 carries the highest quality, channel 1 the next and channel 2 the third.
- R3: When qualities are equal, the candidate from the lower link number wins. Within a single link, the first candidate (sub 0) beats the second (sub 1).
- R4: A candidate with quality 0 is never selected. Any channel left without a candidate outputs an all-zero word.
- R5: Input candidate k sits at bits `[k*12 +: 12]` of `in_cands`, laid out as `{quality[3:0], payload[7:0]}`, with k = 2*(link-1) + sub. A selected word carries `src_id` = link (1 to 9) and `sub` = 0 or 1, and its payload is passed through unchanged.
- R6: Bit k of `win_flags` is 1 exactly when input candidate k is one of the selected words.
- R7: Input sets applied on consecutive clocks each produce their own result on consecutive clocks.
- R8: While reset is held (synchronous, active high), `out_valid`, `out_words` and `win_flags` are all zero.
- R9: A clock with `in_valid` low ignores `in_cands`. Three cycles later it gives all-zero words and all-zero flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per crossing |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_cands` as a live input set |
| in_cands | input | 216 | Eighteen 12-bit candidates, candidate k at `[k*12 +: 12]` |
| out_valid | output | 1 | Result strobe, three cycles after `in_valid` |
| out_words | output | 51 | Three ranked 17-bit picks, channel 0 best |
| win_flags | output | 18 | Winner bit per input candidate |

## Verification
The bench compares every cycle against a behavioural model. It stresses ties, because a design that broke ties by higher index or by link-local order would swap which candidate lands on each channel and would raise the wrong winner bit. It drives sets with fewer than three non-zero candidates, where a design that let empty candidates rank would fill a spare channel with a zero-quality pick and set a flag for it. It places a lone candidate on the last link's second slot to catch an off-by-one link ID or sub bit. It also holds `in_valid` low over busy data and runs long back-to-back random streams, which expose leakage of data into idle results and any stage that fails to advance every clock.

// File: rtl/ranker_pkg.sv
package ranker_pkg;

    parameter int NUM_LINKS      = 9;
    parameter int CANDS_PER_LINK = 2;
    parameter int NUM_SEL        = 3;
    parameter int QUAL_W         = 4;
    parameter int PAY_W          = 8;

    localparam int NUM_CANDS = NUM_LINKS * CANDS_PER_LINK;
    localparam int CAND_W    = QUAL_W + PAY_W;
    localparam int ID_W      = $clog2(NUM_LINKS + 1);
    localparam int SUB_W     = (CANDS_PER_LINK > 1) ? $clog2(CANDS_PER_LINK) : 1;
    localparam int OUT_W     = CAND_W + ID_W + SUB_W;
    localparam int CNT_W     = $clog2(NUM_CANDS + 1);

    typedef struct packed {
        logic [QUAL_W-1:0] quality;
        logic [PAY_W-1:0]  payload;
    } cand_t;

    typedef struct packed {
        cand_t             cand;
        logic [ID_W-1:0]   src_id;
        logic [SUB_W-1:0]  sub;
    } pick_t;

    typedef logic [NUM_CANDS-1:0] candmask_t;

    // a outranks b: higher quality, or equal quality and lower slot index
    function automatic logic outranks(cand_t a, int ia, cand_t b, int ib);
        return (a.quality > b.quality) || ((a.quality == b.quality) && (ia < ib));
    endfunction

    // Tag a candidate with its link number (1-based) and its place in the link
    function automatic pick_t tag_pick(cand_t c, int idx);
        pick_t p;
        p.cand   = c;
        p.src_id = ID_W'(idx / CANDS_PER_LINK + 1);
        p.sub    = SUB_W'(idx % CANDS_PER_LINK);
        return p;
    endfunction

endpackage

// File: rtl/ranker_capture.sv
module ranker_capture
    import ranker_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [NUM_CANDS*CAND_W-1:0] in_cands,
    output cand_t                       cands_q [NUM_CANDS],
    output logic                        valid_q
);

    // Idle crossings are captured as empty candidates so nothing downstream ranks them
    for (genvar k = 0; k < NUM_CANDS; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                cands_q[k] <= '0;
            else if (in_valid)
                cands_q[k] <= cand_t'(in_cands[k*CAND_W +: CAND_W]);
            else
                cands_q[k] <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= in_valid;
    end

endmodule

// File: rtl/ranker_rank.sv
module ranker_rank
    import ranker_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cand_t     cands_d [NUM_CANDS],
    input  logic      valid_d,
    output cand_t     cands_q [NUM_CANDS],
    output candmask_t sel_q   [NUM_SEL],
    output logic      valid_q
);

    logic [CNT_W-1:0] beaten_by [NUM_CANDS];
    candmask_t        sel_c     [NUM_SEL];

    // Count, for each candidate, how many others outrank it
    for (genvar i = 0; i < NUM_CANDS; i++) begin : g_cnt
        always_comb begin
            beaten_by[i] = '0;
            for (int j = 0; j < NUM_CANDS; j++) begin
                if (j != i && outranks(cands_d[j], j, cands_d[i], i))
                    beaten_by[i] = beaten_by[i] + CNT_W'(1);
            end
        end
    end

    // A live candidate outranked by exactly r others owns channel r
    for (genvar r = 0; r < NUM_SEL; r++) begin : g_sel
        always_comb begin
            sel_c[r] = '0;
            for (int i = 0; i < NUM_CANDS; i++)
                sel_c[r][i] = (cands_d[i].quality != '0) && (beaten_by[i] == CNT_W'(r));
        end

        always_ff @(posedge clk) begin
            if (rst) sel_q[r] <= '0;
            else     sel_q[r] <= sel_c[r];
        end

        // R3: ties are resolved, so at most one candidate claims a channel
        a_r3_single_owner: assert property (@(posedge clk) disable iff (rst)
            $onehot0(sel_q[r]));
    end

    for (genvar k = 0; k < NUM_CANDS; k++) begin : g_pass
        always_ff @(posedge clk) begin
            if (rst) cands_q[k] <= '0;
            else     cands_q[k] <= cands_d[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= valid_d;
    end

    for (genvar r = 0; r + 1 < NUM_SEL; r++) begin : g_disj
        // R6: no candidate is placed on two channels
        a_r6_disjoint_ranks: assert property (@(posedge clk) disable iff (rst)
            (sel_q[r] & sel_q[r+1]) == '0);
    end

endmodule

// File: rtl/ranker_select.sv
module ranker_select
    import ranker_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cand_t     cands_d [NUM_CANDS],
    input  candmask_t sel_d   [NUM_SEL],
    input  logic      valid_d,
    output pick_t     words_q [NUM_SEL],
    output candmask_t flags_q,
    output logic      valid_q
);

    pick_t     words_c [NUM_SEL];
    candmask_t flags_c;

    for (genvar r = 0; r < NUM_SEL; r++) begin : g_mux
        always_comb begin
            words_c[r] = '0;
            for (int i = 0; i < NUM_CANDS; i++) begin
                if (sel_d[r][i])
                    words_c[r] = words_c[r] | tag_pick(cands_d[i], i);
            end
        end

        always_ff @(posedge clk) begin
            if (rst) words_q[r] <= '0;
            else     words_q[r] <= words_c[r];
        end
    end

    always_comb begin
        flags_c = '0;
        for (int r = 0; r < NUM_SEL; r++)
            flags_c = flags_c | sel_d[r];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            valid_q <= 1'b0;
        end else begin
            flags_q <= flags_c;
            valid_q <= valid_d;
        end
    end

    // Checker-side count of filled channels
    logic [CNT_W-1:0] filled;
    always_comb begin
        filled = '0;
        for (int r = 0; r < NUM_SEL; r++)
            if (words_q[r].cand.quality != '0) filled = filled + CNT_W'(1);
    end

    for (genvar r = 0; r + 1 < NUM_SEL; r++) begin : g_chk
        // R2: channels carry non-increasing quality
        a_r2_descending: assert property (@(posedge clk) disable iff (rst)
            words_q[r].cand.quality >= words_q[r+1].cand.quality);
        // R4: once a channel is empty, every later one is all-zero
        a_r4_zero_tail: assert property (@(posedge clk) disable iff (rst)
            (words_q[r].cand.quality == '0) |-> (words_q[r+1] == '0));
    end

    // R6: one flag per filled channel
    a_r6_flag_count: assert property (@(posedge clk) disable iff (rst)
        $countones(flags_q) == int'(filled));

    // R9: an idle result raises no winner
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> (flags_q == '0));

endmodule

// File: rtl/top3_ranker.sv
module top3_ranker
    import ranker_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [NUM_CANDS*CAND_W-1:0] in_cands,
    output logic                        out_valid,
    output logic [NUM_SEL*OUT_W-1:0]    out_words,
    output logic [NUM_CANDS-1:0]        win_flags
);

    localparam int PIPE_DEPTH = 3;

    cand_t     cap_cands  [NUM_CANDS];
    logic      cap_valid;
    cand_t     rank_cands [NUM_CANDS];
    candmask_t rank_sel   [NUM_SEL];
    logic      rank_valid;
    pick_t     out_picks  [NUM_SEL];
    candmask_t out_flags;

    ranker_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_cands (in_cands),
        .cands_q  (cap_cands),
        .valid_q  (cap_valid)
    );

    ranker_rank u_rank (
        .clk     (clk),
        .rst     (rst),
        .cands_d (cap_cands),
        .valid_d (cap_valid),
        .cands_q (rank_cands),
        .sel_q   (rank_sel),
        .valid_q (rank_valid)
    );

    ranker_select u_select (
        .clk     (clk),
        .rst     (rst),
        .cands_d (rank_cands),
        .sel_d   (rank_sel),
        .valid_d (rank_valid),
        .words_q (out_picks),
        .flags_q (out_flags),
        .valid_q (out_valid)
    );

    for (genvar r = 0; r < NUM_SEL; r++) begin : g_pack
        assign out_words[r*OUT_W +: OUT_W] = out_picks[r];
    end
    assign win_flags = out_flags;

    // Cycles since reset, saturating, so the latency check never looks before reset
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                                   since_rst <= '0;
        else if (since_rst != 2'(PIPE_DEPTH))      since_rst <= since_rst + 2'd1;
    end

    // R1: strobe follows the input strobe by three edges
    a_r1_latency: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'(PIPE_DEPTH)) |-> (out_valid == $past(in_valid, 3)));

    // R8/R9: an idle output carries no data
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_words == '0));

endmodule

// File: tb/tb_top3_ranker.sv
module tb_top3_ranker;
    import ranker_pkg::*;

    localparam int VEC_W = NUM_CANDS * CAND_W;
    localparam int OW    = NUM_SEL * OUT_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [VEC_W-1:0] in_cands = '0;
    logic             out_valid;
    logic [OW-1:0]    out_words;
    logic [NUM_CANDS-1:0] win_flags;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct {
        logic                 valid;
        logic [OW-1:0]        words;
        logic [NUM_CANDS-1:0] flags;
        string                tag;
    } exp_t;

    exp_t pending[$];

    top3_ranker dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_cands  (in_cands),
        .out_valid (out_valid),
        .out_words (out_words),
        .win_flags (win_flags)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(string tag, string what, logic [OW-1:0] act, logic [OW-1:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Behavioural model: repeatedly take the best remaining non-empty candidate
    function automatic exp_t model(logic v, logic [VEC_W-1:0] vec, string tag);
        exp_t e;
        bit   used [NUM_CANDS];
        e.valid = v;
        e.words = '0;
        e.flags = '0;
        e.tag   = tag;
        foreach (used[k]) used[k] = 1'b0;
        if (v) begin
            for (int r = 0; r < NUM_SEL; r++) begin
                int best = -1;
                for (int k = 0; k < NUM_CANDS; k++) begin
                    int q = int'(vec[k*CAND_W + PAY_W +: QUAL_W]);
                    if (!used[k] && q > 0) begin
                        if (best < 0) best = k;
                        else if (q > int'(vec[best*CAND_W + PAY_W +: QUAL_W])) best = k;
                    end
                end
                if (best >= 0) begin
                    used[best] = 1'b1;
                    e.flags[best] = 1'b1;
                    e.words[r*OUT_W +: OUT_W] = {vec[best*CAND_W +: CAND_W],
                                                 ID_W'(best / CANDS_PER_LINK + 1),
                                                 SUB_W'(best % CANDS_PER_LINK)};
                end
            end
        end
        return e;
    endfunction

    task automatic compare_front();
        exp_t e;
        if (pending.size() == 3) begin
            e = pending.pop_front();
            chk("R1", "out_valid", OW'(out_valid), OW'(e.valid));
            for (int r = 0; r < NUM_SEL; r++)
                chk(e.tag, $sformatf("channel %0d", r),
                    OW'(out_words[r*OUT_W +: OUT_W]), OW'(e.words[r*OUT_W +: OUT_W]));
            chk("R6", "win_flags", OW'(win_flags), OW'(e.flags));
        end
    endtask

    task automatic step(logic v, logic [VEC_W-1:0] vec, string tag);
        @(negedge clk);
        compare_front();
        in_valid = v;
        in_cands = vec;
        pending.push_back(model(v, vec, tag));
    endtask

    function automatic logic [VEC_W-1:0] put(logic [VEC_W-1:0] vec, int k, int q, int pay);
        logic [VEC_W-1:0] o = vec;
        o[k*CAND_W +: CAND_W] = {QUAL_W'(q), PAY_W'(pay)};
        return o;
    endfunction

    function automatic logic [VEC_W-1:0] rnd_vec(int qmax);
        logic [VEC_W-1:0] o = '0;
        for (int k = 0; k < NUM_CANDS; k++)
            o = put(o, k, int'($urandom_range(qmax, 0)), int'($urandom_range(255, 0)));
        return o;
    endfunction

    initial begin
        logic [VEC_W-1:0] v;

        // R8: reset state
        repeat (4) @(negedge clk);
        chk("R8", "out_valid in reset", OW'(out_valid), '0);
        chk("R8", "out_words in reset", out_words, '0);
        chk("R8", "win_flags in reset", OW'(win_flags), '0);
        @(negedge clk);
        rst = 1'b0;

        // R2: distinct qualities scattered over the links
        v = '0;
        v = put(v, 13, 9, 8'hA1);
        v = put(v, 2, 15, 8'h5C);
        v = put(v, 7, 12, 8'h33);
        v = put(v, 16, 3, 8'h77);
        v = put(v, 0, 1, 8'h01);
        step(1'b1, v, "R2");

        // R3: all equal -> link1/sub0, link1/sub1, link2/sub0
        v = '0;
        for (int k = 0; k < NUM_CANDS; k++) v = put(v, k, 5, k + 16);
        step(1'b1, v, "R3");
        // R3: tie across links for second and third place
        v = '0;
        v = put(v, 11, 7, 8'h11);
        v = put(v, 4, 7, 8'h22);
        v = put(v, 5, 7, 8'h44);
        v = put(v, 17, 9, 8'h55);
        step(1'b1, v, "R3");

        // R4: two valid, one valid, none valid
        v = '0;
        v = put(v, 9, 2, 8'hC3);
        v = put(v, 3, 0, 8'hFF);
        v = put(v, 14, 6, 8'h0F);
        step(1'b1, v, "R4");
        v = put('0, 6, 1, 8'h99);
        step(1'b1, v, "R4");
        v = put('0, 10, 0, 8'hEE);
        step(1'b1, v, "R4");

        // R5: last link, second slot -> src_id 9, sub 1
        v = put('0, 17, 4, 8'hB7);
        step(1'b1, v, "R5");
        v = put('0, 1, 4, 8'h4D);
        step(1'b1, v, "R5");

        // R9: busy data with the strobe low
        step(1'b0, rnd_vec(15), "R9");
        step(1'b0, rnd_vec(15), "R9");

        // R7: back-to-back streams, heavy ties then wide spread
        for (int n = 0; n < 300; n++) step(1'b1, rnd_vec(3), "R7");
        for (int n = 0; n < 300; n++) step(1'b1, rnd_vec(15), "R7");
        for (int n = 0; n < 200; n++)
            step(($urandom_range(1, 0) == 1), rnd_vec(2), "R7");

        // Drain
        for (int n = 0; n < 4; n++) step(1'b0, '0, "R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule